// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Dormant Mode

This block takes a single NRZ serial line and rebuilds characters of eight or nine data bits from it. The line rests high. A character starts with one low bit, carries its data least significant bit first, and closes with one high bit. The block first resynchronises the line to the core clock. It then times every bit from a 16x oversampling tick and decides each bit by a three-sample majority near the bit centre. Finished characters go into a holding register, and five status flags report receive-full, overrun, noise, framing error and an idle line. One strobe clears all five flags and stands for reading the holding register.

On a shared line, a node that is not addressed can go dormant by setting the wake bit. While the bit is set, no status flag can rise and idle detection is held off. Hardware clears the bit again by one of two selectable events. In idle-line mode, the event is a full character time of continuous high line. In address-mark mode, the event is a character whose top data bit is set, and that character is then accepted as ordinary data. Software can also set or clear the bit directly.

Top module: `uwr_rx_top`

## Requirements
- R1: After reset, `rx_data` is 0, `rx_bit8`, all five flags and `wake_bit` are 0.
- R2: In 8-bit mode (`nine_bit`=0), the first data bit after the low start bit lands in `rx_data[0]` and the eighth in `rx_data[7]`. A completed character sets `rx_full`.
- R3: In 9-bit mode (`nine_bit`=1), the frame has 11 bit times and the ninth data bit is presented on `rx_bit8`. In 8-bit mode `rx_bit8` reads 0.
- R4: Each bit is sampled three times around its centre and decided by majority. If the three samples of any bit in a character disagree, `rx_noise` is set with that character while the decided data stays correct.
- R5: A stop bit decided low sets `rx_frame_err`. A break (start, all data and stop bits low) loads 0 into `rx_data`, sets `rx_full` and sets `rx_frame_err`.
- R6: A character that completes while `rx_full` is 1 sets `rx_overrun` and leaves `rx_data` and `rx_bit8` unchanged.
- R7: `rx_idle` is set once the line has stayed high for a full frame time (10 bit times in 8-bit mode, 11 in 9-bit mode) after an accepted character. It is not set again until another character is accepted.
- R8: While `wake_bit` is 1, characters are discarded and none of the five flags can become set. This includes breaks, framing errors and idle-line periods.
- R9: With `wake_mode`=0 (idle-line method), a dormant receiver clears `wake_bit` when the line has been high for a full frame time. The next character is then received normally, and the idle period that woke it does not set `rx_idle`.
- R10: With `wake_mode`=1 (address-mark method), a character whose most significant data bit is 1 (bit 7 in 8-bit mode, bit 8 in 9-bit mode) clears `wake_bit` and is loaded with `rx_full` set. Characters with that bit 0 leave the receiver dormant, and idle periods do not wake it.
- R11: A one-cycle `wake_set` pulse sets `wake_bit` and a `wake_clr` pulse clears it. A clear request or a hardware wake event takes priority over `wake_set`. A `flags_clr` pulse clears all five status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously at chip level |
| rx_in | input | 1 | Serial input line, asynchronous to `clk` |
| os_tick | input | 1 | Single-cycle enable at 16 times the bit rate |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_mode | input | 1 | 0 = idle-line wake, 1 = address-mark wake |
| wake_set | input | 1 | Pulse that puts the receiver to sleep |
| wake_clr | input | 1 | Pulse that wakes the receiver by software |
| flags_clr | input | 1 | Pulse that clears all five status flags |
| rx_data | output | 8 | Low eight bits of the last accepted character |
| rx_bit8 | output | 1 | Ninth data bit of the last accepted character |
| rx_full | output | 1 | Holding register holds an unread character |
| rx_idle | output | 1 | Idle line seen after a character |
| rx_overrun | output | 1 | A character was lost because the holding register was full |
| rx_noise | output | 1 | Sample disagreement within the last accepted character |
| rx_frame_err | output | 1 | Stop bit of the last accepted character was low |
| wake_bit | output | 1 | Receiver is dormant |

## Verification
The hardest state to reach is a single disagreeing sample inside one bit. If the glitch lands on two of the three sample points, the vote flips and the data is corrupted. If it lands on none, no noise is seen. The bench drives the line with one clock per oversampling tick, so the two-stage synchroniser and the start-edge detection fix where each bit's samples fall. A one-tick inversion at the ninth tick of a data bit therefore hits only the centre sample, even if the alignment is off by one tick. The dormant cases are reached in fixed sequences: the bench sleeps, sends traffic that should be dropped (including a break in address-mark mode), then gives the wake event and checks that the next character is accepted.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
  // Widest character the receiver assembles
  localparam int unsigned UWR_MAX_DATA = 9;

  typedef enum logic [0:0] {
    FR_HUNT  = 1'b0,
    FR_FRAME = 1'b1
  } fr_state_e;
endpackage

// File: rtl/uwr_sync.sv
module uwr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;   // line rests high
    else        chain_q <= chain_d;
  end

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/uwr_deframer.sv
module uwr_deframer
  import uwr_pkg::*;
#(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = UWR_MAX_DATA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic          nine_bit,
  output logic          done,
  output logic [DW-1:0] word,
  output logic          stop_bit,
  output logic          noisy
);
  localparam int unsigned PW  = $clog2(OVS);
  localparam int unsigned CW  = $clog2(DW + 2);
  localparam int unsigned MID = OVS / 2;

  fr_state_e     state_q, state_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    samp_q, samp_d;
  logic [DW-1:0] word_q, word_d;
  logic          noisy_q, noisy_d;
  logic          stop_q, stop_d;
  logic          done_q, done_d;
  logic          vote, split;
  logic [CW-1:0] stop_idx;

  assign vote     = (samp_q[0] & samp_q[1]) | (samp_q[0] & line) | (samp_q[1] & line);
  assign split    = !((samp_q[0] == samp_q[1]) && (samp_q[1] == line));
  assign stop_idx = nine_bit ? CW'(DW + 1) : CW'(DW);

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    samp_d  = samp_q;
    word_d  = word_q;
    noisy_d = noisy_q;
    stop_d  = stop_q;
    done_d  = 1'b0;
    if (tick) begin
      unique case (state_q)
        FR_HUNT: begin
          if (!line) begin
            state_d = FR_FRAME;
            ph_d    = '0;
            cnt_d   = '0;
            word_d  = '0;
            noisy_d = 1'b0;
          end
        end
        FR_FRAME: begin
          ph_d = ph_q + 1'b1;
          if (ph_q == PW'(MID - 2)) samp_d[0] = line;
          if (ph_q == PW'(MID - 1)) samp_d[1] = line;
          if (ph_q == PW'(MID)) begin
            if (split) noisy_d = 1'b1;
            if (cnt_q == '0) begin
              if (vote) state_d = FR_HUNT;       // false start
            end else if (cnt_q == stop_idx) begin
              done_d  = 1'b1;
              stop_d  = vote;
              state_d = FR_HUNT;
            end else begin
              word_d[cnt_q - 1'b1] = vote;
            end
          end
          if (ph_q == PW'(OVS - 1)) cnt_d = cnt_q + 1'b1;
        end
        default: state_d = FR_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_HUNT;
      ph_q    <= '0;
      cnt_q   <= '0;
      samp_q  <= '1;
      word_q  <= '0;
      noisy_q <= 1'b0;
      stop_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      samp_q  <= samp_d;
      word_q  <= word_d;
      noisy_q <= noisy_d;
      stop_q  <= stop_d;
      done_q  <= done_d;
    end
  end

  assign done     = done_q;
  assign word     = word_q;
  assign stop_bit = stop_q;
  assign noisy    = noisy_q;

  // R3: bit index never runs past the stop position of a 9-bit frame
  a_r3_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FR_FRAME) |-> (cnt_q <= CW'(DW + 1)));

  // R2: one completion strobe per character
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/uwr_idle_timer.sv
module uwr_idle_timer
  import uwr_pkg::*;
#(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = UWR_MAX_DATA
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic nine_bit,
  output logic idle_pulse
);
  localparam int unsigned TW = $clog2((DW + 2) * OVS + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] limit;
  logic          pulse_q, pulse_d;

  assign limit = nine_bit ? TW'((DW + 2) * OVS) : TW'((DW + 1) * OVS);

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (tick) begin
      if (!line) begin
        cnt_d = '0;
      end else if (cnt_q < limit) begin
        cnt_d   = cnt_q + 1'b1;
        pulse_d = (cnt_q == limit - 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= TW'((DW + 2) * OVS);   // start saturated: no event out of reset
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign idle_pulse = pulse_q;

  // R7: one idle event per high stretch
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
endmodule

// File: rtl/uwr_rx_top.sv
module uwr_rx_top
  import uwr_pkg::*;
#(
  parameter int unsigned OVS     = 16,
  parameter int unsigned SYNC_FF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       os_tick,
  input  logic       nine_bit,
  input  logic       wake_mode,
  input  logic       wake_set,
  input  logic       wake_clr,
  input  logic       flags_clr,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       rx_full,
  output logic       rx_idle,
  output logic       rx_overrun,
  output logic       rx_noise,
  output logic       rx_frame_err,
  output logic       wake_bit
);
  localparam int unsigned DW = UWR_MAX_DATA;

  logic          line_s;
  logic          fr_done, fr_stop, fr_noisy, idle_ev;
  logic [DW-1:0] fr_word;

  uwr_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(rx_in), .q_out(line_s)
  );

  uwr_deframer #(.OVS(OVS), .DW(DW)) u_deframer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s), .nine_bit(nine_bit),
    .done(fr_done), .word(fr_word), .stop_bit(fr_stop), .noisy(fr_noisy)
  );

  uwr_idle_timer #(.OVS(OVS), .DW(DW)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s), .nine_bit(nine_bit),
    .idle_pulse(idle_ev)
  );

  logic [7:0] data_q, data_d;
  logic       b8_q, b8_d;
  logic       full_q, full_d, idle_q, idle_d, ovr_q, ovr_d;
  logic       nf_q, nf_d, fe_q, fe_d, armed_q, armed_d;
  logic       wake_q, wake_d;
  logic       top_bit, addr_hit, idle_hit, hw_wake, accept;

  assign top_bit  = nine_bit ? fr_word[DW-1] : fr_word[DW-2];
  assign addr_hit = wake_mode && fr_done && top_bit;
  assign idle_hit = !wake_mode && idle_ev;
  assign hw_wake  = wake_q && (addr_hit || idle_hit);
  assign accept   = fr_done && (!wake_q || addr_hit);

  always_comb begin
    wake_d = wake_q;
    if (wake_clr || hw_wake) wake_d = 1'b0;
    else if (wake_set)       wake_d = 1'b1;
  end

  always_comb begin
    data_d  = data_q;
    b8_d    = b8_q;
    armed_d = armed_q;
    full_d  = flags_clr ? 1'b0 : full_q;
    idle_d  = flags_clr ? 1'b0 : idle_q;
    ovr_d   = flags_clr ? 1'b0 : ovr_q;
    nf_d    = flags_clr ? 1'b0 : nf_q;
    fe_d    = flags_clr ? 1'b0 : fe_q;
    if (accept) begin
      armed_d = 1'b1;
      if (full_d) begin
        ovr_d = 1'b1;
      end else begin
        data_d = fr_word[7:0];
        b8_d   = nine_bit & fr_word[DW-1];
        full_d = 1'b1;
        nf_d   = fr_noisy;
        fe_d   = !fr_stop;
      end
    end else if (idle_ev && !wake_q && armed_q) begin
      idle_d  = 1'b1;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      b8_q    <= 1'b0;
      full_q  <= 1'b0;
      idle_q  <= 1'b0;
      ovr_q   <= 1'b0;
      nf_q    <= 1'b0;
      fe_q    <= 1'b0;
      armed_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      data_q  <= data_d;
      b8_q    <= b8_d;
      full_q  <= full_d;
      idle_q  <= idle_d;
      ovr_q   <= ovr_d;
      nf_q    <= nf_d;
      fe_q    <= fe_d;
      armed_q <= armed_d;
      wake_q  <= wake_d;
    end
  end

  assign rx_data      = data_q;
  assign rx_bit8      = b8_q;
  assign rx_full      = full_q;
  assign rx_idle      = idle_q;
  assign rx_overrun   = ovr_q;
  assign rx_noise     = nf_q;
  assign rx_frame_err = fe_q;
  assign wake_bit     = wake_q;

  // R8: a receiver that stayed dormant raises no flag
  a_r8_dormant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && $past(wake_q)) |->
      (!$rose(full_q) && !$rose(idle_q) && !$rose(ovr_q) && !$rose(nf_q) && !$rose(fe_q)));

  // R6: overrun keeps the earlier character
  a_r6_overrun_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> ($stable(data_q) && $stable(b8_q)));

  // R11: the wake bit only drops on a software clear or a hardware wake event
  a_r11_wake_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_q) |-> $past(wake_clr || hw_wake));

  // R10: an address-mark wake leaves a character in the holding register
  a_r10_addr_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && addr_hit && !flags_clr) |=> full_q);
endmodule

// File: tb/uwr_rx_top_test.sv
module uwr_rx_top_test;
  logic       clk;
  logic       rst_n;
  logic       rx_in;
  logic       os_tick;
  logic       nine_bit;
  logic       wake_mode;
  logic       wake_set;
  logic       wake_clr;
  logic       flags_clr;
  logic [7:0] rx_data;
  logic       rx_bit8, rx_full, rx_idle, rx_overrun, rx_noise, rx_frame_err, wake_bit;

  int checks;
  int fails;

  uwr_rx_top uut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick), .nine_bit(nine_bit),
    .wake_mode(wake_mode), .wake_set(wake_set), .wake_clr(wake_clr), .flags_clr(flags_clr),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_full(rx_full), .rx_idle(rx_idle),
    .rx_overrun(rx_overrun), .rx_noise(rx_noise), .rx_frame_err(rx_frame_err),
    .wake_bit(wake_bit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // One clock per oversampling tick; glitch_at selects a bit (0 = start) whose centre tick is inverted
  task automatic send_frame(input logic [8:0] d, input logic nine, input logic stop, input int glitch_at);
    logic [10:0] bits;
    int nbits;
    nbits = nine ? 11 : 10;
    bits = '0;
    for (int i = 0; i < 9; i++) bits[i+1] = d[i];
    if (!nine) bits[9] = stop; else bits[10] = stop;
    for (int b = 0; b < nbits; b++) begin
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        rx_in = (b == glitch_at && k == 8) ? ~bits[b] : bits[b];
      end
    end
    @(negedge clk);
    rx_in = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic hold_high(input int nbit);
    repeat (nbit * 16) @(negedge clk) rx_in = 1'b1;
  endtask

  task automatic pulse_clr();
    @(negedge clk) flags_clr = 1'b1;
    @(negedge clk) flags_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 data", rx_data, 0);
    check("R1 flags", {rx_bit8, rx_full, rx_idle, rx_overrun, rx_noise, rx_frame_err}, 0);
    check("R1 wake", wake_bit, 0);
  endtask

  task automatic t_basic8();
    nine_bit = 1'b0;
    send_frame(9'h0A5, 1'b0, 1'b1, -1);
    check("R2 data", rx_data, 8'hA5);
    check("R2 full", rx_full, 1);
    check("R2 clean", {rx_noise, rx_frame_err, rx_overrun}, 0);
  endtask

  task automatic t_overrun();
    send_frame(9'h03C, 1'b0, 1'b1, -1);
    check("R6 overrun", rx_overrun, 1);
    check("R6 data kept", rx_data, 8'hA5);
    pulse_clr();
    check("R11 flags cleared", {rx_full, rx_idle, rx_overrun, rx_noise, rx_frame_err}, 0);
  endtask

  task automatic t_nine();
    nine_bit = 1'b1;
    send_frame(9'h12B, 1'b1, 1'b1, -1);
    check("R3 data", rx_data, 8'h2B);
    check("R3 bit8", rx_bit8, 1);
    pulse_clr();
    nine_bit = 1'b0;
    send_frame(9'h100, 1'b0, 1'b1, -1);   // bit 8 unused in 8-bit mode
    check("R3 bit8 in 8-bit", rx_bit8, 0);
    pulse_clr();
  endtask

  task automatic t_framing();
    send_frame(9'h066, 1'b0, 1'b0, -1);
    hold_high(1);
    check("R5 stop low", rx_frame_err, 1);
    check("R5 data", rx_data, 8'h66);
    pulse_clr();
    send_frame(9'h000, 1'b0, 1'b0, -1);   // break: ten low bit times
    hold_high(1);
    check("R5 break fe", rx_frame_err, 1);
    check("R5 break full", rx_full, 1);
    check("R5 break data", rx_data, 0);
    pulse_clr();
  endtask

  task automatic t_noise();
    send_frame(9'h055, 1'b0, 1'b1, 4);   // inverts centre of data bit 3
    check("R4 noise", rx_noise, 1);
    check("R4 data", rx_data, 8'h55);
    pulse_clr();
    send_frame(9'h0C3, 1'b0, 1'b1, -1);
    check("R4 clean", rx_noise, 0);
    pulse_clr();
  endtask

  task automatic t_idle();
    send_frame(9'h00F, 1'b0, 1'b1, -1);
    hold_high(12);
    check("R7 idle set", rx_idle, 1);
    pulse_clr();
    hold_high(12);
    check("R7 idle once", rx_idle, 0);
  endtask

  task automatic t_wake_idle();
    wake_mode = 1'b0;
    @(negedge clk) wake_set = 1'b1;
    @(negedge clk) wake_set = 1'b0;
    check("R11 set", wake_bit, 1);
    send_frame(9'h077, 1'b0, 1'b1, -1);
    send_frame(9'h011, 1'b0, 1'b0, -1);
    check("R8 no flags", {rx_full, rx_frame_err, rx_overrun, rx_noise, rx_idle}, 0);
    check("R9 still asleep", wake_bit, 1);
    hold_high(12);
    check("R9 woke", wake_bit, 0);
    check("R9 no idle flag", rx_idle, 0);
    send_frame(9'h042, 1'b0, 1'b1, -1);
    check("R9 next char", rx_data, 8'h42);
    check("R9 next full", rx_full, 1);
    pulse_clr();
  endtask

  task automatic t_wake_addr();
    wake_mode = 1'b1;
    hold_high(12);   // let the idle flag from the last character go by
    pulse_clr();
    @(negedge clk) wake_set = 1'b1;
    @(negedge clk) wake_set = 1'b0;
    send_frame(9'h012, 1'b0, 1'b1, -1);
    check("R10 no mark", wake_bit, 1);
    check("R8 dropped", rx_full, 0);
    send_frame(9'h000, 1'b0, 1'b0, -1);
    hold_high(12);
    check("R8 break ignored", {rx_frame_err, rx_full, rx_idle}, 0);
    check("R10 idle no wake", wake_bit, 1);
    send_frame(9'h085, 1'b0, 1'b1, -1);
    check("R10 woke", wake_bit, 0);
    check("R10 data", rx_data, 8'h85);
    check("R10 full", rx_full, 1);
    pulse_clr();
  endtask

  task automatic t_sw_wake();
    @(negedge clk) wake_set = 1'b1;
    @(negedge clk) wake_set = 1'b0;
    check("R11 set again", wake_bit, 1);
    @(negedge clk) wake_clr = 1'b1;
    @(negedge clk) wake_clr = 1'b0;
    check("R11 sw clear", wake_bit, 0);
    @(negedge clk) begin wake_set = 1'b1; wake_clr = 1'b1; end
    @(negedge clk) begin wake_set = 1'b0; wake_clr = 1'b0; end
    check("R11 clear priority", wake_bit, 0);
  endtask

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; rx_in = 1'b1; os_tick = 1'b1; nine_bit = 1'b0;
    wake_mode = 1'b0; wake_set = 1'b0; wake_clr = 1'b0; flags_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic8();
    t_overrun();
    t_nine();
    t_framing();
    t_noise();
    t_idle();
    t_wake_idle();
    t_wake_addr();
    t_sw_wake();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule